// File: doc/BRIEF.md
# Interleaving Oscillator Synchronizer

This block supplies the shared timing reference for two converter controllers that run in parallel. One controller is set up as the master: its internal oscillator runs at twice the converter switching frequency and the block drives a square wave of 50% duty on the shared sync line at that rate. The other controller is set up as a slave. It releases the sync line and restarts its own oscillator on every falling edge it receives. Both oscillators emit a one-cycle strobe per oscillator period, and the gate sequencer advances on that strobe.

The oscillator period is set by a half-period value, counted in clock cycles. The master's strobe lines up with the rising edge of its sync output. The slave lines up with the falling edge, which comes half an oscillator period later. That delay is a quarter of a switching period, so the two converters run 90 degrees apart. A slave that receives no edges free-runs at the same programmed period. The sync input passes through a two-flop synchronizer and an edge register, so the slave strobe follows a falling edge by a fixed three clock cycles.

Top module: `sync_phase_unit`

## Requirements
- R1: In master mode with half-period setting H, sync_out is a square wave of period 2H clock cycles that is high for H cycles and low for H cycles.
- R2: In master mode, osc_tick is high for exactly one cycle per oscillator period, in the same cycle that sync_out goes from low to high.
- R3: sync_oe is high only in master mode while enabled. In slave mode sync_oe and sync_out are both held low.
- R4: In slave mode, a falling edge on sync_in produces an osc_tick exactly three clock cycles later, and the oscillator period restarts from that tick.
- R5: With a master's sync_out feeding a slave's sync_in, both use the same setting H and the same 2H tick period. The slave ticks H+3 cycles after the master: half an oscillator period, plus the synchronizer latency.
- R6: A slave with no falling edges on sync_in free-runs, with one osc_tick every 2H cycles starting from the cycle after enable.
- R7: A rising edge or a held high level on sync_in does not move the slave's ticks.
- R8: While disabled there is no osc_tick, and sync_out and sync_oe are low. The first osc_tick after enable appears on the first clock edge that samples enable high.
- R9: A half-period setting of 0 behaves as a setting of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the oscillator when high |
| slave_mode | input | 1 | 1 selects slave, 0 selects master |
| half_period | input | HP_W | Half oscillator period in clock cycles |
| sync_in | input | 1 | Shared sync line as seen by this controller |
| sync_out | output | 1 | Sync drive value; low when not master |
| sync_oe | output | 1 | Output enable for the sync line |
| osc_tick | output | 1 | One-cycle oscillator strobe for the gate sequencer |

## Verification
The hardest case to reach is a slave that is already free-running on its own phase and then re-aligns on a falling edge that arrives at some arbitrary point in its count. A late rising edge must then leave that new phase alone. The bench gets there by driving the slave's sync input from its own register instead of from a master: it lets two free-run periods pass, drops the line in the middle of a period, and raises it again between ticks. In a separate sweep over every small half-period setting, a master's output is wired straight to a slave, so the lag of H+3 and the equal periods are checked cycle by cycle.

// File: rtl/sync_phase_pkg.sv
package sync_phase_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_MASTER = 2'd1,
        MODE_SLAVE  = 2'd2
    } mode_e;

    function automatic mode_e pick_mode(input logic en, input logic slave);
        if (!en) begin
            return MODE_OFF;
        end
        return slave ? MODE_SLAVE : MODE_MASTER;
    endfunction

endpackage

// File: rtl/sync_fall_det.sv
module sync_fall_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic line_in,
    output logic fall
);
    typedef struct packed {
        logic [STAGES:0] pipe;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d      = det_q;
        det_d.pipe = {det_q.pipe[STAGES-1:0], line_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

    // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
    assign fall = arm && det_q.pipe[STAGES] && !det_q.pipe[STAGES-1];

endmodule

// File: rtl/sync_phase_ctr.sv
module sync_phase_ctr #(
    parameter int HP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            drive_sync,
    input  logic            realign,
    input  logic [HP_W-1:0] half_period,
    output logic            sync_level,
    output logic            tick
);
    localparam int CNT_W = HP_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sync;
        logic             tick;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    logic [HP_W-1:0]  half_eff;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        half_eff = (half_period == '0) ? HP_W'(1) : half_period;
        last_cnt = {half_eff, 1'b0} - CNT_W'(1);

        ctr_d = ctr_q;
        if (!run) begin
            ctr_d.cnt = last_cnt;
        end else if (realign) begin
            ctr_d.cnt = '0;
        end else if (ctr_q.cnt >= last_cnt) begin
            ctr_d.cnt = '0;
        end else begin
            ctr_d.cnt = ctr_q.cnt + CNT_W'(1);
        end
        ctr_d.tick = run && (ctr_d.cnt == '0);
        ctr_d.sync = run && drive_sync && (ctr_d.cnt < {1'b0, half_eff});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign sync_level = ctr_q.sync;
    assign tick       = ctr_q.tick;

endmodule

// File: rtl/sync_phase_unit.sv
module sync_phase_unit
    import sync_phase_pkg::*;
#(
    parameter int HP_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            slave_mode,
    input  logic [HP_W-1:0] half_period,
    input  logic            sync_in,
    output logic            sync_out,
    output logic            sync_oe,
    output logic            osc_tick
);
    typedef struct packed {
        logic oe;
    } top_t;

    top_t  top_d, top_q;
    mode_e mode;
    logic  run, drive, arm, fall;

    always_comb begin
        mode     = pick_mode(enable, slave_mode);
        run      = (mode != MODE_OFF);
        drive    = (mode == MODE_MASTER);
        arm      = (mode == MODE_SLAVE);
        top_d    = top_q;
        top_d.oe = drive;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    sync_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .line_in (sync_in),
        .fall    (fall)
    );

    sync_phase_ctr #(.HP_W(HP_W)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .drive_sync  (drive),
        .realign     (fall),
        .half_period (half_period),
        .sync_level  (sync_out),
        .tick        (osc_tick)
    );

    assign sync_oe = top_q.oe;

endmodule

// File: rtl/sync_phase_unit_chk.sv
module sync_phase_unit_chk #(
    parameter int HP_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable,
    input logic            slave_mode,
    input logic [HP_W-1:0] half_period,
    input logic            sync_in,
    input logic            sync_out,
    input logic            sync_oe,
    input logic            osc_tick
);
    assert_quiet_when_not_master_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode || !enable) |=> (!sync_out && !sync_oe));

    assert_oe_only_master_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_oe |-> $past(enable && !slave_mode));

    assert_tick_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sync_out) && $past(sync_oe) && $stable(half_period)
         && ($past(half_period) == $past(half_period, 2))) |-> osc_tick);

    assert_slave_lock_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && slave_mode && $fell(sync_in)) |-> ##3 osc_tick);

    assert_no_tick_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !osc_tick);
endmodule

bind sync_phase_unit sync_phase_unit_chk #(.HP_W(HP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .slave_mode  (slave_mode),
    .half_period (half_period),
    .sync_in     (sync_in),
    .sync_out    (sync_out),
    .sync_oe     (sync_oe),
    .osc_tick    (osc_tick)
);

// File: tb/sync_phase_unit_test.sv
module sync_phase_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_en = 1'b0;
    logic       s_en = 1'b0;
    logic [7:0] hp = 8'd1;
    logic       use_master = 1'b0;
    logic       ext_sync = 1'b1;
    logic       m_sync, m_oe, m_tick;
    logic       s_sync, s_oe, s_tick;
    logic       s_in;
    int         errors = 0;
    int         checks = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    assign s_in = use_master ? m_sync : ext_sync;

    sync_phase_unit uut (
        .clk(clk), .rst_n(rst_n), .enable(m_en), .slave_mode(1'b0),
        .half_period(hp), .sync_in(1'b1),
        .sync_out(m_sync), .sync_oe(m_oe), .osc_tick(m_tick)
    );

    sync_phase_unit uut_s (
        .clk(clk), .rst_n(rst_n), .enable(s_en), .slave_mode(1'b1),
        .half_period(hp), .sync_in(s_in),
        .sync_out(s_sync), .sync_oe(s_oe), .osc_tick(s_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // reset state
        repeat (2) @(negedge clk);
        check(m_tick == 1'b0 && m_sync == 1'b0 && m_oe == 1'b0, "R8 reset master", int'(m_tick), 0);
        check(s_tick == 1'b0 && s_sync == 1'b0 && s_oe == 1'b0, "R8 reset slave", int'(s_tick), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // master feeding slave, every small half-period setting (0 behaves as 1, R9)
        for (int h = 0; h <= 6; h++) begin
            int he;
            int lag;
            he = (h == 0) ? 1 : h;
            lag = he + 3;
            hp = 8'(h);
            use_master = 1'b1;
            repeat (4) @(negedge clk);
            m_en = 1'b1;
            s_en = 1'b1;
            for (int k = 0; k < 6 * he + 8; k++) begin
                bit exp_sync, exp_mt, exp_st;
                @(negedge clk);
                exp_sync = (k % (2 * he)) < he;
                exp_mt   = (k % (2 * he)) == 0;
                if (k < lag) exp_st = (k % (2 * he)) == 0;
                else         exp_st = ((k - lag) % (2 * he)) == 0;
                if (k == 0) check(m_tick == 1'b1, "R8 first tick on enable", int'(m_tick), 1);
                check(m_sync == exp_sync, (h == 0) ? "R9 sync level" : "R1 sync level", int'(m_sync), int'(exp_sync));
                check(m_tick == exp_mt, "R2 master tick", int'(m_tick), int'(exp_mt));
                check(m_oe == 1'b1, "R3 master oe", int'(m_oe), 1);
                check(s_sync == 1'b0 && s_oe == 1'b0, "R3 slave quiet", int'(s_oe), 0);
                check(s_tick == exp_st, "R5 slave tick lag", int'(s_tick), int'(exp_st));
            end
            use_master = 1'b0;
            repeat (4) @(negedge clk);
            m_en = 1'b0;
            s_en = 1'b0;
            @(negedge clk);
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                check(m_tick == 1'b0 && m_sync == 1'b0 && m_oe == 1'b0, "R8 disabled quiet", int'(m_tick), 0);
                check(s_tick == 1'b0, "R8 slave disabled", int'(s_tick), 0);
            end
        end

        // slave alone: free-run, re-align on a late falling edge, ignore a rising edge
        hp = 8'd3;
        ext_sync = 1'b1;
        use_master = 1'b0;
        repeat (4) @(negedge clk);
        s_en = 1'b1;
        for (int k = 0; k <= 32; k++) begin
            bit exp_st;
            @(negedge clk);
            if (k < 17) exp_st = (k % 6) == 0;
            else        exp_st = ((k - 17) % 6) == 0;
            if (k < 14)      check(s_tick == exp_st, "R6 free-run tick", int'(s_tick), int'(exp_st));
            else if (k < 21) check(s_tick == exp_st, "R4 realign tick", int'(s_tick), int'(exp_st));
            else             check(s_tick == exp_st, "R7 rise ignored", int'(s_tick), int'(exp_st));
            check(s_sync == 1'b0 && s_oe == 1'b0, "R3 slave quiet", int'(s_sync), 0);
            if (k == 14) ext_sync = 1'b0;
            if (k == 20) ext_sync = 1'b1;
        end
        s_en = 1'b0;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule